// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns a system clock into CAN bit timing. A programmable prescaler produces one time-quantum tick every `cfg_presc + 1` clocks. Each bit starts with a one-quantum synchronization segment. Segment 1 follows, merging propagation and the first phase buffer. Segment 2, the second phase buffer, ends the bit. The received line passes through a two-flop synchronizer. It is sampled once per bit, at the end of segment 1, and the block reports this with a sample strobe and the sampled level. A second strobe marks the last quantum of each bit, so that a transmit path can launch its next bit there.

Only recessive-to-dominant edges, seen between consecutive quanta, are used to keep the block aligned with other nodes. While the bus is idle, a qualified edge restarts the bit (hard synchronization). During a frame, the edge moves the sample point instead (resynchronization). An edge in segment 1 lengthens segment 1. An edge in segment 2 ends the bit early. Each correction is clamped to the jump width. A node that is transmitting ignores edges that would lengthen segment 1.

The intended settings include 16 quanta per bit (13 and 2 quanta for the two segments, jump width 1) and 20 quanta per bit (16 and 3, jump width 1). A 250 kbit/s link needs a quantum of 250 ns or 200 ns respectively.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts `cfg_presc + 1` clocks. With no edges on the line, consecutive sample strobes are `1 + cfg_seg1 + cfg_seg2` quanta apart. The first sample strobe after reset comes `cfg_seg1` quanta after reset release.
- R2: The transmit strobe is high during the last quantum of segment 2. In an undisturbed bit it comes `cfg_seg2` quanta after the sample strobe, and it never shares a cycle with the sample strobe.
- R3: `sample_bit` carries the synchronized receive level when the sample strobe is high (1 = recessive, 0 = dominant). The synchronizer adds two clocks of delay.
- R4: A rising (dominant-to-recessive) transition never changes the bit timing.
- R5: A falling transition is used only if the previous sample was recessive (1).
- R6: At most one synchronization takes effect per bit. Further qualified edges in the same bit are ignored.
- R7: With `bus_idle` high, a qualified edge makes the quantum in which it is seen the synchronization segment. The next sample strobe then follows `cfg_seg1` quanta later.
- R8: With `bus_idle` low and `transmitting` low, an edge seen in quantum c of segment 1 (c from 0) lengthens segment 1 by min(c + 1, `cfg_sjw`) quanta.
- R9: With `transmitting` high, an edge in segment 1 leaves the timing unchanged. Edges in segment 2 are still used.
- R10: With `bus_idle` low, an edge seen in quantum c of segment 2 has error e = `cfg_seg2` - c. If e exceeds `cfg_sjw`, the bit ends `cfg_sjw` quanta early.
- R11: If e is at most `cfg_sjw`, the quantum in which the edge is seen becomes the synchronization segment of the next bit, and the transmit strobe is high in that quantum.
- R12: Both strobes are high only on a quantum tick, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_presc | input | PRESC_W | Quantum length minus one, in clocks |
| cfg_seg1 | input | SEG1_W | Segment 1 length in quanta (at least 2) |
| cfg_seg2 | input | SEG2_W | Segment 2 length in quanta (at least 1) |
| cfg_sjw | input | SJW_W | Jump width in quanta (1 up to `cfg_seg1`) |
| rx_raw | input | 1 | Asynchronous receive line, 1 = recessive |
| transmitting | input | 1 | Node is driving a frame |
| bus_idle | input | 1 | Bus idle, enables hard synchronization |
| sample_strobe | output | 1 | Sample point of the current bit |
| sample_bit | output | 1 | Sampled level, valid with the strobe |
| tx_strobe | output | 1 | Last quantum of the bit; launch next bit |

## Verification
The bench uses the default widths. It runs most scenarios with a one-clock quantum, so every edge position inside a bit can be placed to the exact quantum and each correction appears as a plain change in the sample-strobe spacing. Longer prescaler settings with the 16- and 20-quanta layouts confirm the quantum scaling and the place of the transmit strobe. A jump width of 2 to 3 with a 4-quantum segment 2 separates partial from full shortening, and clamped from unclamped lengthening.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } seg_e;

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    output logic               tq_tick
);

    logic [PRESC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tq_tick = (cnt_q == presc);
        cnt_d   = tq_tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/can_bt_rx_edge.sv
module can_bt_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw,
    input  logic tq_tick,
    output logic rx_lvl,
    output logic fall_edge
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_d, prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= rx_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_comb begin
        rx_lvl    = chain_q[SYNC_STAGES-1];
        fall_edge = tq_tick && prev_q && !rx_lvl;
        prev_d    = tq_tick ? rx_lvl : prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/can_bt_seg_fsm.sv
module can_bt_seg_fsm
    import can_bt_pkg::*;
#(
    parameter int SEG1_W = 5,
    parameter int SEG2_W = 4,
    parameter int SJW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tq_tick,
    input  logic              rx_lvl,
    input  logic              fall_edge,
    input  logic              transmitting,
    input  logic              bus_idle,
    input  logic [SEG1_W-1:0] cfg_seg1,
    input  logic [SEG2_W-1:0] cfg_seg2,
    input  logic [SJW_W-1:0]  cfg_sjw,
    output logic              sample_strobe,
    output logic              sample_bit,
    output logic              tx_strobe
);

    localparam int CNT_W = ((SEG1_W > SEG2_W) ? SEG1_W : SEG2_W) + 1;
    localparam int EW    = CNT_W + 1;

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [SJW_W-1:0] ext;
        logic [SJW_W-1:0] shr;
        logic             synced;
        logic             last_smp;
    } fsm_t;

    fsm_t st_d, st_q;

    logic [EW-1:0] cnt_x, seg1_x, seg2_x, sjw_x;
    logic [EW-1:0] pos_err, neg_err, jump_pos, jump_neg;
    logic [EW-1:0] ext_eff, shr_eff;
    logic          edge_ok, hard, rs_pos, rs_neg, rs_zero, full_neg;
    logic          seg1_end, seg2_end;

    always_comb begin
        cnt_x    = EW'(st_q.cnt);
        seg1_x   = EW'(cfg_seg1);
        seg2_x   = EW'(cfg_seg2);
        sjw_x    = EW'(cfg_sjw);

        pos_err  = cnt_x + 1'b1;
        neg_err  = seg2_x - cnt_x;
        jump_pos = (pos_err < sjw_x) ? pos_err : sjw_x;
        jump_neg = (neg_err < sjw_x) ? neg_err : sjw_x;

        edge_ok  = fall_edge && !st_q.synced && st_q.last_smp;
        hard     = edge_ok && bus_idle;
        rs_pos   = edge_ok && !bus_idle && (st_q.seg == SEG_ONE) && !transmitting;
        rs_neg   = edge_ok && !bus_idle && (st_q.seg == SEG_TWO);
        rs_zero  = edge_ok && !bus_idle && (st_q.seg == SEG_SYNC);
        full_neg = rs_neg && (neg_err <= sjw_x);

        ext_eff  = rs_pos ? jump_pos : EW'(st_q.ext);
        shr_eff  = rs_neg ? jump_neg : EW'(st_q.shr);
        seg1_end = (cnt_x + 1'b1) == (seg1_x + ext_eff);
        seg2_end = (cnt_x + 1'b1 + shr_eff) == seg2_x;

        sample_strobe = 1'b0;
        tx_strobe     = 1'b0;
        sample_bit    = rx_lvl;
        st_d          = st_q;

        if (tq_tick) begin
            if (hard) begin
                st_d.seg    = SEG_ONE;
                st_d.cnt    = '0;
                st_d.ext    = '0;
                st_d.shr    = '0;
                st_d.synced = 1'b1;
            end else begin
                unique case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg    = SEG_ONE;
                        st_d.cnt    = '0;
                        st_d.synced = st_q.synced || rs_zero;
                    end
                    SEG_ONE: begin
                        if (seg1_end) begin
                            sample_strobe = 1'b1;
                            st_d.last_smp = rx_lvl;
                            st_d.seg      = SEG_TWO;
                            st_d.cnt      = '0;
                            st_d.ext      = '0;
                        end else begin
                            st_d.cnt    = st_q.cnt + 1'b1;
                            st_d.ext    = SJW_W'(ext_eff);
                            st_d.synced = st_q.synced || rs_pos;
                        end
                    end
                    SEG_TWO: begin
                        if (full_neg) begin
                            tx_strobe   = 1'b1;
                            st_d.seg    = SEG_ONE;
                            st_d.cnt    = '0;
                            st_d.shr    = '0;
                            st_d.synced = 1'b1;
                        end else if (seg2_end) begin
                            tx_strobe   = 1'b1;
                            st_d.seg    = SEG_SYNC;
                            st_d.cnt    = '0;
                            st_d.shr    = '0;
                            st_d.synced = 1'b0;
                        end else begin
                            st_d.cnt    = st_q.cnt + 1'b1;
                            st_d.shr    = SJW_W'(shr_eff);
                            st_d.synced = st_q.synced || rs_neg;
                        end
                    end
                    default: begin
                        st_d.seg = SEG_SYNC;
                        st_d.cnt = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seg      <= SEG_SYNC;
            st_q.cnt      <= '0;
            st_q.ext      <= '0;
            st_q.shr      <= '0;
            st_q.synced   <= 1'b0;
            st_q.last_smp <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int PRESC_W     = 6,
    parameter int SEG1_W      = 5,
    parameter int SEG2_W      = 4,
    parameter int SJW_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [SEG1_W-1:0]  cfg_seg1,
    input  logic [SEG2_W-1:0]  cfg_seg2,
    input  logic [SJW_W-1:0]   cfg_sjw,
    input  logic               rx_raw,
    input  logic               transmitting,
    input  logic               bus_idle,
    output logic               sample_strobe,
    output logic               sample_bit,
    output logic               tx_strobe
);

    logic tq_tick;
    logic rx_lvl;
    logic fall_edge;

    can_bt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .presc   (cfg_presc),
        .tq_tick (tq_tick)
    );

    can_bt_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_raw    (rx_raw),
        .tq_tick   (tq_tick),
        .rx_lvl    (rx_lvl),
        .fall_edge (fall_edge)
    );

    can_bt_seg_fsm #(
        .SEG1_W (SEG1_W),
        .SEG2_W (SEG2_W),
        .SJW_W  (SJW_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tq_tick       (tq_tick),
        .rx_lvl        (rx_lvl),
        .fall_edge     (fall_edge),
        .transmitting  (transmitting),
        .bus_idle      (bus_idle),
        .cfg_seg1      (cfg_seg1),
        .cfg_seg2      (cfg_seg2),
        .cfg_sjw       (cfg_sjw),
        .sample_strobe (sample_strobe),
        .sample_bit    (sample_bit),
        .tx_strobe     (tx_strobe)
    );

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic tq_tick,
    input logic sample_strobe,
    input logic tx_strobe
);

    p_sample_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> tq_tick);

    p_tx_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> tq_tick);

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_strobe && tx_strobe));

    p_sample_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    p_tx_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);

endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tq_tick       (tq_tick),
    .sample_strobe (sample_strobe),
    .tx_strobe     (tx_strobe)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_presc = '0;
    logic [4:0] cfg_seg1 = 5'd13;
    logic [3:0] cfg_seg2 = 4'd2;
    logic [1:0] cfg_sjw = 2'd1;
    logic       rx_raw = 1'b1;
    logic       transmitting = 1'b0;
    logic       bus_idle = 1'b0;
    logic       sample_strobe, sample_bit, tx_strobe;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int last_tx = -1;
    bit done = 0;

    can_bit_timer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_presc     (cfg_presc),
        .cfg_seg1      (cfg_seg1),
        .cfg_seg2      (cfg_seg2),
        .cfg_sjw       (cfg_sjw),
        .rx_raw        (rx_raw),
        .transmitting  (transmitting),
        .bus_idle      (bus_idle),
        .sample_strobe (sample_strobe),
        .sample_bit    (sample_bit),
        .tx_strobe     (tx_strobe)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (tx_strobe) last_tx = cyc;
    endtask

    task automatic wait_sample(output int s, output int b);
        do step(); while (!sample_strobe);
        s = cyc;
        b = int'(sample_bit);
    endtask

    task automatic goto_cyc(input int d);
        if (cyc > d) chk("bench timing", cyc, d);
        while (cyc < d) step();
    endtask

    task automatic pulse_at(input int d);
        goto_cyc(d);
        rx_raw = 1'b0;
        step();
        rx_raw = 1'b1;
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int exp_pos(input int c, input int sjw, input bit txing);
        return txing ? 0 : imin(c + 1, sjw);
    endfunction

    function automatic int exp_neg(input int c, input int seg2, input int sjw);
        return imin(seg2 - c, sjw);
    endfunction

    task automatic do_reset(input int presc, input int s1, input int s2, input int sjw,
                            output int rel);
        rst_n = 1'b0;
        rx_raw = 1'b1;
        transmitting = 1'b0;
        bus_idle = 1'b0;
        cfg_presc = 6'(presc);
        cfg_seg1 = 5'(s1);
        cfg_seg2 = 4'(s2);
        cfg_sjw = 2'(sjw);
        repeat (3) step();
        chk("R12 reset sample_strobe", int'(sample_strobe), 0);
        chk("R12 reset tx_strobe", int'(tx_strobe), 0);
        rst_n = 1'b1;
        rel = cyc;
    endtask

    initial begin
        int rel, s, s2, s3, b, p, seg1, seg2, sjw;
        int seed_sink;
        seed_sink = $urandom(32'd20240611);

        // R1 R2: 16-quantum layout, one clock per quantum
        do_reset(0, 13, 2, 1, rel);
        wait_sample(s, b);
        chk("R1 first sample after reset", s - rel, 13);
        chk("R3 idle sample bit", b, 1);
        for (int i = 0; i < 3; i++) begin
            wait_sample(s2, b);
            chk("R1 spacing 16 quanta", s2 - s, 16);
            chk("R2 tx after sample", last_tx - s, 2);
            s = s2;
        end

        // R1 R2: prescaler 4 clocks per quantum
        do_reset(3, 13, 2, 1, rel);
        wait_sample(s, b);
        wait_sample(s2, b);
        chk("R1 spacing presc 3", s2 - s, 64);
        chk("R2 tx distance presc 3", last_tx - s, 8);

        // R1 R2: 20-quantum layout, prescaler 5
        do_reset(4, 16, 3, 1, rel);
        wait_sample(s, b);
        wait_sample(s2, b);
        chk("R1 spacing 20 quanta", s2 - s, 100);
        chk("R2 tx distance 20 quanta", last_tx - s, 15);

        // R7: hard sync while idle, edge at segment 1 quantum 5
        do_reset(0, 13, 2, 1, rel);
        bus_idle = 1'b1;
        wait_sample(s, b);
        pulse_at(s + 2 + 5);
        wait_sample(s2, b);
        chk("R7 hard sync restart", s2 - s, 16 + 1 + 5);
        bus_idle = 1'b0;

        // R8: same edge, not idle, clamped to jump width 1
        wait_sample(s, b);
        wait_sample(s, b);
        pulse_at(s + 2 + 5);
        wait_sample(s2, b);
        chk("R8 resync clamp sjw1", s2 - s, 16 + 1);

        // Layout 10/4, jump width 2: P = 15
        seg1 = 10; seg2 = 4; sjw = 2; p = 1 + seg1 + seg2;
        do_reset(0, seg1, seg2, sjw, rel);
        wait_sample(s, b);

        // R6: two edges in one bit, only the first acts
        wait_sample(s, b);
        pulse_at(s + seg2 + 0);
        pulse_at(s + seg2 + 4);
        wait_sample(s2, b);
        chk("R6 single sync per bit", s2 - s, p + 1);

        // R9: transmitter ignores positive error, keeps negative
        transmitting = 1'b1;
        wait_sample(s, b);
        wait_sample(s, b);
        pulse_at(s + seg2 + 4);
        wait_sample(s2, b);
        chk("R9 tx ignores positive", s2 - s, p);
        wait_sample(s, b);
        pulse_at(s + 3 - 1);
        wait_sample(s2, b);
        chk("R9 tx keeps negative", s2 - s, p - 1);
        transmitting = 1'b0;

        // R10: partial shortening, segment 2 quantum 1, error 3
        wait_sample(s, b);
        wait_sample(s, b);
        pulse_at(s + 1 - 1);
        wait_sample(s2, b);
        chk("R10 partial shorten", s2 - s, p - 2);

        // R11: full shortening, segment 2 quantum 3, error 1
        wait_sample(s, b);
        wait_sample(s, b);
        pulse_at(s + 3 - 1);
        wait_sample(s2, b);
        chk("R11 full shorten spacing", s2 - s, p - 1);
        chk("R11 tx in edge quantum", last_tx - s, 1 + 3);

        // R3 R4: hold dominant, then a rising edge in segment 1
        wait_sample(s, b);
        wait_sample(s, b);
        transmitting = 1'b1;
        goto_cyc(s + seg2 + 0);
        rx_raw = 1'b0;
        wait_sample(s2, b);
        chk("R3 dominant sampled", b, 0);
        chk("R3 timing unchanged", s2 - s, p);
        transmitting = 1'b0;
        goto_cyc(s2 + seg2 + 3);
        rx_raw = 1'b1;
        wait_sample(s3, b);
        chk("R4 rising ignored", s3 - s2, p);
        chk("R3 recessive sampled", b, 1);

        // R5: previous sample dominant, falling edge not used
        transmitting = 1'b1;
        wait_sample(s, b);
        goto_cyc(s + seg2 + 0);
        rx_raw = 1'b0;
        wait_sample(s, b);
        transmitting = 1'b0;
        goto_cyc(s + 1);
        rx_raw = 1'b1;
        goto_cyc(s + seg2 + 3);
        rx_raw = 1'b0;
        wait_sample(s2, b);
        chk("R5 unqualified edge", s2 - s, p);
        chk("R5 sample dominant", b, 0);
        goto_cyc(s2 + 1);
        rx_raw = 1'b1;

        // Random edges, R8 R9 R10 R11, jump width 1..3
        for (int w = 1; w <= 3; w++) begin
            do_reset(0, seg1, seg2, w, rel);
            wait_sample(s, b);
            for (int it = 0; it < 8; it++) begin
                int c, dlt;
                bit in_two, txr;
                in_two = 1'($urandom_range(0, 1));
                txr = 1'($urandom_range(0, 1));
                transmitting = txr;
                wait_sample(s, b);
                wait_sample(s, b);
                if (in_two) begin
                    c = $urandom_range(1, seg2 - 1);
                    dlt = -exp_neg(c, seg2, w);
                    pulse_at(s + c - 1);
                end else begin
                    c = $urandom_range(0, seg1 - 2);
                    dlt = exp_pos(c, w, txr);
                    pulse_at(s + seg2 + c);
                end
                wait_sample(s2, b);
                chk(in_two ? "R10 R11 random negative" : "R8 R9 random positive",
                    s2 - s, p + dlt);
                chk("R3 random sample bit", b, 1);
            end
            transmitting = 1'b0;
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule